// File: doc/BRIEF.md
# I2C Slave Read-Direction Transmitter

This block is the part of an I2C target that answers read requests. It watches oversampled copies of the open-drain SDA and SCL lines on a faster system clock. It finds START and STOP conditions and collects the address byte. When the address names this device with the read direction, it acknowledges, holds SCL low and pulses an interrupt. The host then loads a data byte and releases the clock. The byte goes out on SDA with the most significant bit first.

After each byte the master's acknowledge bit is sampled. If the master acknowledges, SCL is held low again and a further interrupt asks for the next byte. If the master does not acknowledge, the block returns to idle without stretching the clock and without an interrupt.

A ten-bit addressing mode is also supported. In that mode the master first writes the two-byte address. It then issues a repeated START and resends the header byte with the read bit set.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, sda_drive_low, scl_drive_low, tx_full, read_mode and tx_irq are all 0.
- R2: In seven-bit mode (ten_bit_mode=0), an address byte whose bits 7:1 equal own_addr[6:0] and whose bit 0 is 1 (read) is acknowledged: the block drives SDA low during the ninth SCL clock.
- R3: At the falling edge of the ninth clock of a matched read address, read_mode becomes 1, SCL is held low and tx_irq pulses high for exactly one system clock.
- R4: An address byte that does not match, or a matching seven-bit address with bit 0 = 0 (write), is not acknowledged. It causes no SCL hold and no interrupt, and read_mode stays 0.
- R5: A tx_wr pulse sets tx_full. A release_scl pulse while tx_full is 0 is ignored, and SCL stays held low.
- R6: A release_scl pulse while tx_full is 1 stops driving SCL. The loaded byte then appears on SDA with the most significant bit first, changing only while SCL is low. tx_full returns to 0 after the eighth falling edge of SCL.
- R7: During the ninth clock of a data byte the block does not drive SDA. If the master drives SDA low there (ACK), SCL is held low again after the ninth falling edge and tx_irq pulses once.
- R8: If SDA is high during the ninth clock of a data byte (NACK), the block raises no interrupt, does not hold SCL and clears read_mode.
- R9: A STOP (SDA rising while SCL is high) at any point releases both lines and clears read_mode.
- R10: In ten-bit mode (ten_bit_mode=1), the header byte 11110, own_addr[9:8], 0 is acknowledged, and a second byte equal to own_addr[7:0] is acknowledged with no hold and no interrupt. After a repeated START, the header byte with bit 0 = 1 is acknowledged and behaves as R3.
- R11: In ten-bit mode, a read header is not acknowledged unless the matching write header and low address byte were acknowledged immediately before it, with no STOP between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_drive_low | output | 1 | Enables the pull-down on SDA |
| scl_drive_low | output | 1 | Enables the pull-down on SCL (clock stretch) |
| own_addr | input | 10 | Device address (bits 6:0 are used in seven-bit mode) |
| ten_bit_mode | input | 1 | Selects ten-bit addressing |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit byte loaded and not yet sent |
| release_scl | input | 1 | Host command to end the clock stretch |
| read_mode | output | 1 | A read transfer addressed to this device is active |
| tx_irq | output | 1 | One-clock request for the next byte |

## Verification
A bus edge passes two synchronizer flops and one edge register before the state changes. The pins follow one clock after that, so a result shows at the outputs three to four system clocks after the SCL or SDA edge that causes it. The bench model holds each SCL phase for at least twelve clocks. It changes SDA only after SCL has been low for six clocks, and it samples slave data and the acknowledge in the middle of the SCL high phase. It checks holds, interrupts and status at least ten clocks after the ninth falling edge, with every drive and sample on the falling system-clock edge.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam logic [4:0] HDR10_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR1, ST_ADR2, ST_AACK, ST_HOLD, ST_SEND, ST_MACK
  } stx_state_e;

  typedef enum logic [1:0] {
    NX_NONE, NX_READ, NX_ADR2, NX_ARM
  } stx_after_ack_e;
endpackage

// File: rtl/i2c_stx_sync.sv
module i2c_stx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  output logic sda_s,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] sda_chain, scl_chain;
  logic sda_prev, scl_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sda_chain <= '1;
          scl_chain <= '1;
        end else begin
          sda_chain[0] <= sda_in;
          scl_chain[0] <= scl_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sda_chain <= '1;
          scl_chain <= '1;
        end else begin
          sda_chain <= {sda_chain[STAGES-2:0], sda_in};
          scl_chain <= {scl_chain[STAGES-2:0], scl_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_prev <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_prev <= sda_s;
      scl_prev <= scl_s;
    end
  end

  assign sda_s    = sda_chain[STAGES-1];
  assign scl_s    = scl_chain[STAGES-1];
  assign scl_rise = scl_s && !scl_prev;
  assign scl_fall = !scl_s && scl_prev;
  assign start_p  = scl_s && scl_prev && sda_prev && !sda_s;
  assign stop_p   = scl_s && scl_prev && !sda_prev && sda_s;

  p_start_stop_excl_r9: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !stop_p);
endmodule

// File: rtl/i2c_stx_addr.sv
module i2c_stx_addr
  import i2c_stx_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit7_read,
  output logic              hdr_write,
  output logic              hdr_read,
  output logic              low_hit
);
  logic hdr_match;

  assign hit7_read = rx_byte[0] && (rx_byte[7:1] == own_addr[6:0]);
  assign hdr_match = (rx_byte[7:3] == HDR10_PREFIX) && (rx_byte[2:1] == own_addr[9:8]);
  assign hdr_write = hdr_match && !rx_byte[0];
  assign hdr_read  = hdr_match && rx_byte[0];
  assign low_hit   = (rx_byte == own_addr[7:0]);
endmodule

// File: rtl/i2c_stx_txbuf.sv
module i2c_stx_txbuf
  import i2c_stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load,
  input  logic              shift_en,
  input  logic              drain,
  output logic              full,
  output logic              out_bit
);
  logic [BYTE_W-1:0] hold_q, shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      shreg_q <= '0;
      full    <= 1'b0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      if (load) shreg_q <= hold_q;
      else if (shift_en) shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
      if (wr_en) full <= 1'b1;
      else if (drain) full <= 1'b0;
    end
  end

  assign out_bit = shreg_q[BYTE_W-1];

  p_full_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> full);
  p_empty_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
    (drain && !wr_en) |=> !full);
endmodule

// File: rtl/i2c_stx_ctrl.sv
module i2c_stx_ctrl
  import i2c_stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              ten_bit_mode,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              release_req,
  input  logic              buf_full,
  input  logic              buf_bit,
  output logic              buf_load,
  output logic              buf_shift,
  output logic              buf_drain,
  output logic              sda_low,
  output logic              scl_low,
  output logic              read_mode,
  output logic              irq
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  stx_state_e        st;
  stx_after_ack_e    after_ack, adr_next;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_q;
  logic armed_q, mack_q, read_q, irq_q, sda_low_q, scl_low_q;
  logic hit7_rd, hdr_wr, hdr_rd, low_hit, adr_ack, quiet, byte_end;

  i2c_stx_addr u_addr (
    .rx_byte  (rx_q),
    .own_addr (own_addr),
    .hit7_read(hit7_rd),
    .hdr_write(hdr_wr),
    .hdr_read (hdr_rd),
    .low_hit  (low_hit)
  );

  assign quiet    = !start_p && !stop_p;
  assign byte_end = scl_fall && (cnt == LAST_RX);

  always_comb begin
    adr_ack  = 1'b0;
    adr_next = NX_NONE;
    if (st == ST_ADR1) begin
      if (!ten_bit_mode) begin
        if (hit7_rd) begin
          adr_ack  = 1'b1;
          adr_next = NX_READ;
        end
      end else if (hdr_wr) begin
        adr_ack  = 1'b1;
        adr_next = NX_ADR2;
      end else if (hdr_rd && armed_q) begin
        adr_ack  = 1'b1;
        adr_next = NX_READ;
      end
    end else if (st == ST_ADR2 && low_hit) begin
      adr_ack  = 1'b1;
      adr_next = NX_ARM;
    end
  end

  assign buf_load  = quiet && (st == ST_HOLD) && release_req && buf_full;
  assign buf_shift = quiet && (st == ST_SEND) && scl_fall && (cnt != LAST_TX);
  assign buf_drain = quiet && (st == ST_SEND) && scl_fall && (cnt == LAST_TX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      after_ack <= NX_NONE;
      cnt       <= '0;
      rx_q      <= '0;
      armed_q   <= 1'b0;
      mack_q    <= 1'b0;
      read_q    <= 1'b0;
      irq_q     <= 1'b0;
      sda_low_q <= 1'b0;
      scl_low_q <= 1'b0;
    end else begin
      irq_q     <= 1'b0;
      sda_low_q <= (st == ST_AACK) || (st == ST_SEND && !buf_bit);
      scl_low_q <= (st == ST_HOLD);
      if (start_p) begin
        st     <= ST_ADR1;
        cnt    <= '0;
        read_q <= 1'b0;
      end else if (stop_p) begin
        st      <= ST_IDLE;
        cnt     <= '0;
        read_q  <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        unique case (st)
          ST_ADR1, ST_ADR2: begin
            if (scl_rise && cnt != LAST_RX) begin
              rx_q <= {rx_q[BYTE_W-2:0], sda_s};
              cnt  <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt       <= '0;
              after_ack <= adr_next;
              st        <= adr_ack ? ST_AACK : ST_IDLE;
              if (st == ST_ADR1) armed_q <= 1'b0;
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              unique case (after_ack)
                NX_READ: begin
                  st     <= ST_HOLD;
                  read_q <= 1'b1;
                  irq_q  <= 1'b1;
                end
                NX_ADR2: st <= ST_ADR2;
                NX_ARM: begin
                  armed_q <= 1'b1;
                  st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
              endcase
            end
          end
          ST_HOLD: begin
            if (buf_load) begin
              st  <= ST_SEND;
              cnt <= '0;
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (cnt == LAST_TX) begin
                st  <= ST_MACK;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack_q <= !sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                st    <= ST_HOLD;
                irq_q <= 1'b1;
              end else begin
                st     <= ST_IDLE;
                read_q <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_low   = sda_low_q;
  assign scl_low   = scl_low_q;
  assign read_mode = read_q;
  assign irq       = irq_q;

  p_irq_one_clk_r3: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  p_irq_then_hold_r3: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> scl_low_q);
  p_hold_needs_data_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !buf_full && quiet) |=> (st == ST_HOLD));
  p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_low_q) && !$past(stop_p)) |-> !scl_s);
  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MACK && scl_fall && !mack_q && quiet) |=> (st == ST_IDLE && !irq_q));
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> ##1 (!sda_low_q && !scl_low_q));
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_stx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_drive_low,
  output logic              scl_drive_low,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ten_bit_mode,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              release_scl,
  output logic              read_mode,
  output logic              tx_irq
);
  logic sda_s, scl_s, scl_rise, scl_fall, start_p, stop_p;
  logic buf_load, buf_shift, buf_drain, buf_bit;

  i2c_stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sda_in  (sda_in),
    .scl_in  (scl_in),
    .sda_s   (sda_s),
    .scl_s   (scl_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_p (start_p),
    .stop_p  (stop_p)
  );

  i2c_stx_txbuf u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tx_wr),
    .wr_data (tx_data),
    .load    (buf_load),
    .shift_en(buf_shift),
    .drain   (buf_drain),
    .full    (tx_full),
    .out_bit (buf_bit)
  );

  i2c_stx_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sda_s       (sda_s),
    .scl_s       (scl_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_p     (start_p),
    .stop_p      (stop_p),
    .ten_bit_mode(ten_bit_mode),
    .own_addr    (own_addr),
    .release_req (release_scl),
    .buf_full    (tx_full),
    .buf_bit     (buf_bit),
    .buf_load    (buf_load),
    .buf_shift   (buf_shift),
    .buf_drain   (buf_drain),
    .sda_low     (sda_drive_low),
    .scl_low     (scl_drive_low),
    .read_mode   (read_mode),
    .irq         (tx_irq)
  );
endmodule

// File: tb/i2c_slave_tx_bench.sv
`timescale 1ns/1ps
module i2c_slave_tx_bench;
  localparam int HALF = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic m_sda = 1'b1, m_scl = 1'b1;
  logic sda_bus, scl_bus;
  logic sda_drive_low, scl_drive_low, tx_full, read_mode, tx_irq;
  logic [9:0] own_addr = 10'h03A;
  logic ten_bit_mode = 1'b0;
  logic tx_wr = 1'b0, release_scl = 1'b0;
  logic [7:0] tx_data = 8'h00;

  assign sda_bus = m_sda & ~sda_drive_low;
  assign scl_bus = m_scl & ~scl_drive_low;

  i2c_slave_tx u_i2c_slave_tx (
    .clk(clk), .rst(rst), .sda_in(sda_bus), .scl_in(scl_bus),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
    .release_scl(release_scl), .read_mode(read_mode), .tx_irq(tx_irq)
  );

  int checks = 0, fails = 0, irq_seen = 0, irq_exp = 0;
  bit done = 1'b0;

  always @(posedge clk) if (!rst && tx_irq) irq_seen <= irq_seen + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s, output logic slv);
    m_sda = b;
    wait_cyc(HALF);
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
    wait_cyc(HALF / 2);
    s = sda_bus;
    slv = sda_drive_low;
    wait_cyc(HALF / 2);
    m_scl = 1'b0;
    wait_cyc(6);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s, v;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s, v);
    clk_bit(1'b1, s, v);
    acked = ~s;
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] d, output logic slv_ack);
    logic s, v;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s, v);
      d[i] = s;
    end
    clk_bit(~m_ack, s, v);
    slv_ack = v;
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wait_cyc(HALF);
    m_scl = 1'b0; wait_cyc(6);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wait_cyc(HALF);
    m_scl = 1'b1; wait_cyc(HALF);
    m_sda = 1'b0; wait_cyc(HALF);
    m_scl = 1'b0; wait_cyc(6);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_cyc(HALF);
    m_scl = 1'b1; wait_cyc(HALF);
    m_sda = 1'b1; wait_cyc(HALF);
  endtask

  task automatic host_load(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic host_release();
    release_scl = 1'b1;
    @(negedge clk);
    release_scl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack, slv, s, v;
    logic [7:0] d;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(3);
    // R1 reset state
    check("R1", "sda_drive_low", sda_drive_low, 0);
    check("R1", "scl_drive_low", scl_drive_low, 0);
    check("R1", "tx_full", tx_full, 0);
    check("R1", "read_mode", read_mode, 0);
    check("R1", "irq count", irq_seen, 0);

    // R2 R3: seven-bit read address
    bus_start();
    send_byte(8'h75, ack);
    check("R2", "address ack", ack, 1);
    wait_cyc(4);
    irq_exp = 1;
    check("R3", "scl held", scl_drive_low, 1);
    check("R3", "read_mode", read_mode, 1);
    check("R3", "irq count", irq_seen, irq_exp);

    // R5: release with empty buffer
    host_release();
    wait_cyc(20);
    check("R5", "scl still held", scl_drive_low, 1);
    host_load(8'hA5);
    check("R5", "tx_full after write", tx_full, 1);

    // R6 R7: byte with master ACK
    host_release();
    wait_cyc(4);
    check("R6", "scl released", scl_drive_low, 0);
    read_byte(1'b1, d, slv);
    check("R6", "data byte", d, 8'hA5);
    check("R7", "slave drives sda in ack slot", slv, 0);
    wait_cyc(4);
    irq_exp = 2;
    check("R6", "tx_full cleared", tx_full, 0);
    check("R7", "scl held after ack", scl_drive_low, 1);
    check("R7", "irq count", irq_seen, irq_exp);

    // R8: byte with master NACK
    host_load(8'h3C);
    host_release();
    read_byte(1'b0, d, slv);
    check("R6", "second data byte", d, 8'h3C);
    wait_cyc(4);
    check("R8", "scl not held", scl_drive_low, 0);
    check("R8", "irq count", irq_seen, irq_exp);
    check("R8", "read_mode cleared", read_mode, 0);
    check("R8", "sda released", sda_drive_low, 0);
    bus_stop();

    // R4: write direction and wrong address
    bus_start();
    send_byte(8'h74, ack);
    check("R4", "write address ack", ack, 0);
    wait_cyc(4);
    check("R4", "no hold on write", scl_drive_low, 0);
    check("R4", "irq count", irq_seen, irq_exp);
    bus_stop();
    bus_start();
    send_byte(8'h77, ack);
    check("R4", "wrong address ack", ack, 0);
    wait_cyc(4);
    check("R4", "read_mode", read_mode, 0);
    check("R4", "no hold", scl_drive_low, 0);
    bus_stop();

    // R9: STOP in the middle of a byte
    bus_start();
    send_byte(8'h75, ack);
    irq_exp = 3;
    host_load(8'hFF);
    host_release();
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s, v);
    bus_stop();
    wait_cyc(6);
    check("R9", "sda released", sda_drive_low, 0);
    check("R9", "scl released", scl_drive_low, 0);
    check("R9", "read_mode cleared", read_mode, 0);
    check("R9", "irq count", irq_seen, irq_exp);

    // R10: ten-bit read via repeated START
    ten_bit_mode = 1'b1;
    own_addr = 10'h2C7;
    bus_start();
    send_byte(8'hF4, ack);
    check("R10", "header write ack", ack, 1);
    send_byte(8'hC7, ack);
    check("R10", "low byte ack", ack, 1);
    wait_cyc(4);
    check("R10", "no hold after low byte", scl_drive_low, 0);
    check("R10", "no irq after low byte", irq_seen, irq_exp);
    bus_rstart();
    send_byte(8'hF5, ack);
    check("R10", "header read ack", ack, 1);
    wait_cyc(4);
    irq_exp = 4;
    check("R10", "scl held", scl_drive_low, 1);
    check("R10", "read_mode", read_mode, 1);
    check("R10", "irq count", irq_seen, irq_exp);
    host_load(8'h5A);
    host_release();
    read_byte(1'b0, d, slv);
    check("R10", "data byte", d, 8'h5A);
    bus_stop();

    // R11: read header without a matched write pair
    bus_start();
    send_byte(8'hF5, ack);
    check("R11", "lone read header ack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hF4, ack);
    send_byte(8'hC6, ack);
    check("R11", "wrong low byte ack", ack, 0);
    bus_rstart();
    send_byte(8'hF5, ack);
    check("R11", "read header after bad low byte", ack, 0);
    wait_cyc(4);
    check("R11", "read_mode", read_mode, 0);
    check("R11", "irq count", irq_seen, irq_exp);
    bus_stop();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule